// File: doc/BRIEF.md
# I2C Byte-Sequenced Bus Master

This block is an I2C master that a processor steps through a transfer one byte at a time, using three byte-wide registers. A control register sets the SCL rate, enables ACK generation for received bytes, enables the interrupt and holds the byte-done flag. A status/command register selects transmit or receive mode, issues start and stop commands, and reports activity and the last acknowledge. A data register holds the byte to send, or the byte just received. The block drives the open-drain SCL and SDA lines through active-high pull-low enables and reads SDA back through a two-stage synchronizer.

Each byte ends with an acknowledge slot. After that slot the block raises its done flag and keeps SCL low. Software then reads or loads the data register and may write a command. When software clears the flag, the block does one of three things: it shifts the next byte, it issues a repeated start, or it issues a stop. A transfer opens with a start command from an idle bus. The byte after any start is always sent out as the address byte. Every later byte follows the mode bit. To finish a read, software clears the ACK enable before releasing the last byte, so that byte is answered with a NACK.

The register interface is a plain single-cycle write strobe with a combinational read. It has no back-pressure. Software paces the bus through the done flag.

Top module: `i2cm_master`

## Requirements
- R1: After reset, SCL and SDA are both released (`scl_oe`=0, `sda_oe`=0), `irq` is 0, and the control (address 0), status (address 1) and data (address 2) registers all read 0x00. Whenever the engine is idle, both lines stay released.
- R2: A status write with bit 7=1, bit 4=1 and bit 5=1 on an idle bus produces a start condition (SDA falls while SCL is high). The data register is then sent MSB first as the address byte, with the last bit being R/W (0 write, 1 read).
- R3: Inside a start, byte or stop sequence, SDA changes only while SCL is low. The only exceptions are the start edge and the stop edge, so the bus shows exactly one start per start command and one stop per stop command.
- R4: After each byte's acknowledge slot, control bit 4 (done flag) reads 1 and SCL is held low. Writing control with bit 4=0 clears the flag. Writing it with bit 4=1 leaves the flag set and the bus frozen.
- R5: In every transmitted byte, status bit 0 records the SDA level sampled in the acknowledge slot: 0 for ACK, 1 for NACK.
- R6: With status bits [7:6]=2'b10 (receive), each byte after the address byte is sampled MSB first into the data register. The master answers it with ACK (SDA low) when control bit 7 is 1, and with NACK (SDA released) when control bit 7 is 0. Bits [7:6]=2'b11 select transmit.
- R7: A command written while the bus is frozen takes effect when the done flag is cleared. Bit 5=0 gives a stop (SDA rises while SCL is high), after which status bit 5 (busy) reads 0. Bit 5=1 gives a repeated start with no stop before it.
- R8: Each quarter of an SCL bit lasts D×(N+1) clock cycles, where N is control bits [3:0] and D is DIV_LO when control bit 6 is 0 or DIV_HI when it is 1. SCL rising edges within a byte are therefore 4×D×(N+1) cycles apart.
- R9: A data-register write is ignored while a start, byte or stop sequence is in progress. A status write with bit 7 or bit 4 clear issues no start and no stop.
- R10: `irq` equals the done flag AND control bit 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_addr | input | 2 | Register select: 0 control, 1 status/command, 2 data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Byte-done interrupt request |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_i | input | 1 | SDA level seen on the bus |

## Verification
Two situations are hard to reach from the ports: a repeated start, and a NACK on the last received byte. Both need a slave that acknowledges its address, switches direction on the R/W bit and supplies data. The bench therefore models an open-drain slave at address 0x50. This slave logs every start, stop, received byte and master acknowledge. The read scenario writes a register byte, commands a repeated start with a read address, receives one byte with ACK enabled and one with it cleared, and then checks the acknowledge levels the slave saw. Separate scenarios probe the frozen bus by writing 1 to the done flag, loading data mid-byte, and issuing a command with its enable bit clear.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_BIT,
    ST_HOLD,
    ST_STOP
  } eng_state_t;

  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_START,
    CMD_STOP
  } cmd_t;

  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_STAT = 2'd1;
  localparam logic [1:0] RA_DATA = 2'd2;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/i2cm_tick_gen.sv
module i2cm_tick_gen #(
  parameter int DIV_LO = 4,
  parameter int DIV_HI = 16,
  parameter int SCALE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               div_sel,
  input  logic [SCALE_W-1:0] scale,
  output logic               tick
);
  localparam int DMAX = (DIV_HI > DIV_LO) ? DIV_HI : DIV_LO;
  localparam int MAXCNT = DMAX * (1 << SCALE_W);
  localparam int CW = $clog2(MAXCNT + 1);

  logic [CW-1:0] cnt, limit;

  always_comb begin
    limit = CW'((div_sel ? DIV_HI : DIV_LO) * (int'(scale) + 1) - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (!en) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= limit) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  // R8: a quarter-bit strobe is a single-cycle pulse when the period exceeds one cycle
  assert_tick_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && en && limit != '0 && $stable(limit)) |=> !tick);
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
#(
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start_req,
  input  logic          stop_req,
  input  logic          pend,
  input  logic          mode_tx,
  input  logic          ack_en,
  input  logic          ld_data,
  input  logic [BW-1:0] ld_val,
  input  logic          sda_in,
  output logic          busy,
  output logic          shifting,
  output logic          done,
  output logic          nack,
  output logic [BW-1:0] sh_out,
  output logic          scl_low,
  output logic          sda_low
);
  localparam int CNT_W = $clog2(BW + 1);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BW);

  eng_state_t       state;
  cmd_t             cmd;
  logic [1:0]       ph;
  logic [CNT_W-1:0] bitn;
  logic             dir_tx;
  logic [BW-1:0]    sh;

  assign busy     = (state != ST_IDLE);
  assign shifting = (state == ST_START) || (state == ST_BIT) || (state == ST_STOP);
  assign sh_out   = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cmd     <= CMD_NONE;
      ph      <= 2'd0;
      bitn    <= '0;
      dir_tx  <= 1'b0;
      sh      <= '0;
      nack    <= 1'b0;
      done    <= 1'b0;
      scl_low <= 1'b0;
      sda_low <= 1'b0;
    end else begin
      done <= 1'b0;
      if (ld_data && !shifting) sh <= ld_val;
      unique case (state)
        ST_IDLE: begin
          scl_low <= 1'b0;
          sda_low <= 1'b0;
          cmd     <= CMD_NONE;
          if (start_req) begin
            state <= ST_START;
            ph    <= 2'd0;
          end
        end
        ST_HOLD: begin
          sda_low <= 1'b0;
          if (start_req)     cmd <= CMD_START;
          else if (stop_req) cmd <= CMD_STOP;
          if (!pend && !done) begin
            ph  <= 2'd0;
            cmd <= CMD_NONE;
            case (cmd)
              CMD_STOP: begin
                state   <= ST_STOP;
                sda_low <= 1'b1;
              end
              CMD_START: state <= ST_START;
              default: begin
                state  <= ST_BIT;
                bitn   <= '0;
                dir_tx <= mode_tx;
              end
            endcase
          end
        end
        ST_START: if (tick) begin
          ph <= ph + 2'd1;
          case (ph)
            2'd0: scl_low <= 1'b0;
            2'd1: sda_low <= 1'b1;
            2'd2: scl_low <= 1'b1;
            default: begin
              state  <= ST_BIT;
              bitn   <= '0;
              dir_tx <= 1'b1;
            end
          endcase
        end
        ST_BIT: if (tick) begin
          ph <= ph + 2'd1;
          case (ph)
            2'd0: begin
              if (bitn == ACK_SLOT) sda_low <= !dir_tx && ack_en;
              else                  sda_low <= dir_tx && !sh[BW-1];
            end
            2'd1: scl_low <= 1'b0;
            2'd2: begin
              if (bitn == ACK_SLOT) begin
                if (dir_tx) nack <= sda_in;
              end else begin
                sh <= {sh[BW-2:0], sda_in};
              end
            end
            default: begin
              scl_low <= 1'b1;
              if (bitn == ACK_SLOT) begin
                state <= ST_HOLD;
                done  <= 1'b1;
              end else begin
                bitn <= bitn + 1'b1;
              end
            end
          endcase
        end
        ST_STOP: if (tick) begin
          ph <= ph + 2'd1;
          case (ph)
            2'd0: ;
            2'd1: scl_low <= 1'b0;
            2'd2: sda_low <= 1'b0;
            default: state <= ST_IDLE;
          endcase
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: no SDA movement while SCL stays high inside a byte
  assert_sda_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BIT && !scl_low && !$past(scl_low)) |-> $stable(sda_low));

  // R2: the start edge happens with SCL released
  assert_start_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_START && $rose(sda_low)) |-> !scl_low);

  // R7: the stop edge happens with SCL released
  assert_stop_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STOP && $fell(sda_low)) |-> !scl_low);
endmodule

// File: rtl/i2cm_master.sv
module i2cm_master
  import i2cm_pkg::*;
#(
  parameter int DIV_LO = 4,
  parameter int DIV_HI = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       sda_i
);
  logic       ack_en, div_sel, irq_en, pend, txen;
  logic [3:0] scale;
  logic [1:0] mode;
  logic       sda_s1, sda_s2;
  logic       tick, busy, shifting, done, nack;
  logic [7:0] sh;
  logic       wr_ctrl, wr_stat, wr_data, start_req, stop_req;

  assign wr_ctrl   = reg_wr && (reg_addr == RA_CTRL);
  assign wr_stat   = reg_wr && (reg_addr == RA_STAT);
  assign wr_data   = reg_wr && (reg_addr == RA_DATA);
  assign start_req = wr_stat && reg_wdata[7] && reg_wdata[4] && reg_wdata[5];
  assign stop_req  = wr_stat && reg_wdata[7] && reg_wdata[4] && !reg_wdata[5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_s1 <= 1'b1;
      sda_s2 <= 1'b1;
    end else begin
      sda_s1 <= sda_i;
      sda_s2 <= sda_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_en  <= 1'b0;
      div_sel <= 1'b0;
      irq_en  <= 1'b0;
      pend    <= 1'b0;
      scale   <= 4'd0;
      mode    <= 2'd0;
      txen    <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ack_en  <= reg_wdata[7];
        div_sel <= reg_wdata[6];
        irq_en  <= reg_wdata[5];
        scale   <= reg_wdata[3:0];
      end
      if (done)                         pend <= 1'b1;
      else if (wr_ctrl && !reg_wdata[4]) pend <= 1'b0;
      if (wr_stat) begin
        mode <= reg_wdata[7:6];
        txen <= reg_wdata[4];
      end
    end
  end

  always_comb begin
    case (reg_addr)
      RA_CTRL: reg_rdata = {ack_en, div_sel, irq_en, pend, scale};
      RA_STAT: reg_rdata = {mode, busy, txen, 3'b000, nack};
      RA_DATA: reg_rdata = sh;
      default: reg_rdata = 8'h00;
    endcase
  end

  assign irq = pend && irq_en;

  i2cm_tick_gen #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI), .SCALE_W(4)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(shifting), .div_sel(div_sel),
    .scale(scale), .tick(tick)
  );

  i2cm_engine #(.BW(8)) u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start_req(start_req),
    .stop_req(stop_req), .pend(pend), .mode_tx(mode[0]), .ack_en(ack_en),
    .ld_data(wr_data), .ld_val(reg_wdata), .sda_in(sda_s2), .busy(busy),
    .shifting(shifting), .done(done), .nack(nack), .sh_out(sh),
    .scl_low(scl_oe), .sda_low(sda_oe)
  );

  // R4: while the done flag is up the clock line is pulled low
  assert_hold_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> scl_oe);

  // R4: the done flag only rises after the engine finishes an acknowledge slot
  assert_pend_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(done));

  // R1: an idle engine leaves both lines released
  assert_idle_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));
endmodule

// File: tb/sim_i2cm_master.sv
`timescale 1ns/1ps
module sim_i2cm_master;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq, scl_oe, sda_oe;
  logic       s_oe = 1'b0;
  wire        scl_w = ~scl_oe;
  wire        sda_w = ~(sda_oe | s_oe);

  i2cm_master #(.DIV_LO(4), .DIV_HI(16)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_i(sda_w)
  );

  int nchk = 0, nerr = 0;
  bit finished = 1'b0;

  // slave model at address 0x50
  logic       prev_scl = 1'b1, prev_sda = 1'b1;
  int         bitn = 0;
  logic [7:0] rx = 8'h00, tx = 8'h00, nxt = 8'hA5, addr_last = 8'h00;
  logic       first = 1'b0, sl_rd = 1'b0, sending = 1'b0, mack = 1'b0;
  int         n_start = 0, n_stop = 0, rx_cnt = 0, mack_cnt = 0;
  logic [7:0] rx_log [0:15];
  logic       mack_log [0:7];
  int         cyc = 0, last_rise = 0, per = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    prev_scl <= scl_w;
    prev_sda <= sda_w;
    if (scl_w && !prev_scl) begin
      per <= cyc - last_rise;
      last_rise <= cyc;
    end
    if (scl_w && prev_scl && prev_sda && !sda_w) begin
      n_start <= n_start + 1;
      bitn <= 0; first <= 1'b1; sl_rd <= 1'b0; sending <= 1'b0; s_oe <= 1'b0;
    end else if (scl_w && prev_scl && !prev_sda && sda_w) begin
      n_stop <= n_stop + 1;
      sending <= 1'b0; s_oe <= 1'b0; first <= 1'b0; sl_rd <= 1'b0;
    end else if (scl_w && !prev_scl) begin
      if (bitn < 8) rx <= {rx[6:0], sda_w};
      else if (bitn == 8) mack <= sda_w;
      bitn <= bitn + 1;
    end else if (!scl_w && prev_scl) begin
      if (bitn == 8) begin
        if (!sending) begin
          if (first) begin
            addr_last <= rx;
            first <= 1'b0;
            if (rx[7:1] == 7'h50) begin
              s_oe <= 1'b1;
              sl_rd <= rx[0];
            end
          end else begin
            rx_log[rx_cnt[3:0]] <= rx;
            rx_cnt <= rx_cnt + 1;
            s_oe <= 1'b1;
          end
        end else begin
          s_oe <= 1'b0;
        end
      end else if (bitn == 9) begin
        bitn <= 0;
        s_oe <= 1'b0;
        if (sending) begin
          mack_log[mack_cnt[2:0]] <= mack;
          mack_cnt <= mack_cnt + 1;
        end
        if (sl_rd && (!sending || !mack)) begin
          sending <= 1'b1;
          tx <= nxt;
          nxt <= nxt + 8'h01;
          s_oe <= ~nxt[7];
        end else begin
          sending <= 1'b0;
        end
      end else if (sending && bitn >= 1 && bitn <= 7) begin
        s_oe <= ~tx[7 - bitn];
      end
    end
  end

  task automatic chk(input string rq, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_pend(input string rq);
    logic [7:0] v;
    for (int i = 0; i < 20000; i++) begin
      rd(2'd0, v);
      if (v[4]) return;
    end
    chk({rq, " done flag timeout"}, 0, 1);
  endtask

  task automatic wait_idle(input string rq);
    logic [7:0] v;
    for (int i = 0; i < 20000; i++) begin
      rd(2'd1, v);
      if (!v[5]) return;
    end
    chk({rq, " idle timeout"}, 0, 1);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(2'd0, v); chk("R1 ctrl reset", v, 8'h00);
    rd(2'd1, v); chk("R1 stat reset", v, 8'h00);
    rd(2'd2, v); chk("R1 data reset", v, 8'h00);
    chk("R1 lines released", {scl_oe, sda_oe, irq}, 0);
  endtask

  task automatic t_write();
    logic [7:0] v;
    int s0, rc;
    wr(2'd0, 8'h20);
    wr(2'd2, 8'hA0);
    s0 = n_start;
    wr(2'd1, 8'hF0);
    wait_pend("R2");
    chk("R2 one start", n_start, s0 + 1);
    chk("R2 address byte", addr_last, 8'hA0);
    rd(2'd1, v); chk("R5 ack recorded", v[0], 0);
    chk("R10 irq with enable", irq, 1);
    chk("R8 period N=0 lo", per, 16);
    repeat (100) @(negedge clk);
    chk("R4 scl held", scl_oe, 1);
    rc = rx_cnt;
    wr(2'd0, 8'h30);
    repeat (150) @(negedge clk);
    rd(2'd0, v); chk("R4 write one keeps flag", v[4], 1);
    chk("R4 bus frozen", rx_cnt, rc);
    wr(2'd0, 8'h10);
    chk("R10 irq masked", irq, 0);
    wr(2'd2, 8'h3C);
    wr(2'd1, 8'hE0);
    wr(2'd0, 8'h20);
    repeat (40) @(negedge clk);
    wr(2'd2, 8'hFF);
    wait_pend("R9");
    chk("R9 mid-byte data write ignored", rx_log[rc[3:0]], 8'h3C);
    chk("R9 disabled command no start", n_start, s0 + 1);
    s0 = n_stop;
    wr(2'd1, 8'hD0);
    wr(2'd0, 8'h20);
    wait_idle("R7");
    chk("R7 stop seen", n_stop, s0 + 1);
    rd(2'd1, v); chk("R7 busy clear", v[5], 0);
    chk("R1 released after stop", {scl_oe, sda_oe, irq}, 0);
  endtask

  task automatic t_nack();
    logic [7:0] v;
    wr(2'd0, 8'h00);
    wr(2'd2, 8'hEE);
    wr(2'd1, 8'hF0);
    wait_pend("R5");
    rd(2'd1, v); chk("R5 nack recorded", v[0], 1);
    wr(2'd1, 8'hD0);
    wr(2'd0, 8'h00);
    wait_idle("R5");
  endtask

  task automatic t_read();
    logic [7:0] v;
    int st, sp, m0, rc;
    wr(2'd0, 8'h80);
    wr(2'd2, 8'hA0);
    wr(2'd1, 8'hF0);
    wait_pend("R6");
    rc = rx_cnt;
    wr(2'd2, 8'h07);
    wr(2'd0, 8'h80);
    wait_pend("R6");
    chk("R6 register byte", rx_log[rc[3:0]], 8'h07);
    wr(2'd2, 8'hA1);
    wr(2'd1, 8'hB0);
    st = n_start; sp = n_stop;
    wr(2'd0, 8'h80);
    wait_pend("R7");
    chk("R7 repeated start", n_start, st + 1);
    chk("R7 no stop before restart", n_stop, sp);
    chk("R2 read address", addr_last, 8'hA1);
    rd(2'd1, v); chk("R6 mode readback", v[7:6], 2);
    m0 = mack_cnt;
    wr(2'd0, 8'h80);
    wait_pend("R6");
    rd(2'd2, v); chk("R6 first read byte", v, 8'hA5);
    wr(2'd0, 8'h00);
    wait_pend("R6");
    rd(2'd2, v); chk("R6 last read byte", v, 8'hA6);
    chk("R6 master ack", mack_log[m0[2:0]], 0);
    chk("R6 master nack", mack_log[m0[2:0] + 3'd1], 1);
    wr(2'd1, 8'h90);
    wr(2'd0, 8'h00);
    wait_idle("R7");
    chk("R7 stop after read", n_stop, sp + 1);
  endtask

  task automatic t_rate();
    wr(2'd0, 8'h01);
    wr(2'd2, 8'hA0);
    wr(2'd1, 8'hF0);
    wait_pend("R8");
    chk("R8 period N=1 lo", per, 32);
    wr(2'd0, 8'h40);
    wait_pend("R8");
    chk("R8 period N=0 hi", per, 64);
    wr(2'd1, 8'hD0);
    wr(2'd0, 8'h40);
    wait_idle("R8");
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_write();
    t_nack();
    t_read();
    t_rate();
    chk("R3 total starts", n_start, 5);
    chk("R3 total stops", n_stop, 4);
    finished = 1'b1;
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
    end
  end
endmodule